// File: doc/BRIEF.md
# Bus-Controlled Cycle Stopwatch

This block is a clock-cycle stopwatch that a processor runs over an AXI4-Lite slave port. A two-bit control word sets the counter running, halts it, or zeroes it. A second register returns the live count. The count advances once per clock, so at a nominal 125 MHz clock one count is 8 ns. The eight most significant bits of the count drive an LED bar, which gives a coarse view of elapsed time with no software involved.

Software clears the counter, starts it, waits, stops it, and then reads the count. Only single-beat transfers are supported. Every transfer gets an OKAY response. The clear is synchronous to the counter clock. The active-low reset is asynchronous and sets everything to zero.

Top module: `cyclewatch_top`

## Requirements
- R1: After the active-low reset `rstN` is released, the count, the control word, `ledOut`, `bValid` and `rValid` are all zero.
- R2: While the control word is 1 (bit 0 = run, bit 1 = zero), the count grows by exactly one per clock. Two count reads accepted two cycles apart differ by 2.
- R3: While the control word is 0, the count holds its value.
- R4: Writing 2 zeroes the count. When both control bits are set (value 3), zeroing wins and the count stays at 0.
- R5: The control word sits at byte offset 0x00. A write stores data bits 1:0 and discards bits 31:2. A read returns the stored two bits with bits 31:2 as zero.
- R6: A read at byte offset 0x08 returns the count, zero-extended to 32 bits, as it stood in the cycle the read address was accepted. A control write accepted at edge k takes effect on the count from edge k+1.
- R7: A write to 0x08 or to any offset other than 0x00 and 0x08 changes nothing. A read of an unmapped offset returns 0. All write and read responses are OKAY (code 0).
- R8: `ledOut` equals the top eight bits of the count (bits CNT_W-1 down to CNT_W-8).
- R9: The count wraps from all ones to zero and keeps running, with no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| awAddr | input | ADDR_W | Write address |
| awValid | input | 1 | Write address valid |
| awReady | output | 1 | Write address accepted |
| wData | input | 32 | Write data |
| wStrb | input | 4 | Write byte strobes (not used) |
| wValid | input | 1 | Write data valid |
| wReady | output | 1 | Write data accepted |
| bResp | output | 2 | Write response, always OKAY |
| bValid | output | 1 | Write response valid |
| bReady | input | 1 | Write response taken |
| arAddr | input | ADDR_W | Read address |
| arValid | input | 1 | Read address valid |
| arReady | output | 1 | Read address accepted |
| rData | output | 32 | Read data |
| rResp | output | 2 | Read response, always OKAY |
| rValid | output | 1 | Read data valid |
| rReady | input | 1 | Read data taken |
| ledOut | output | 8 | Top eight count bits |

## Verification
A stored control word that is wrong shows up at the next read of offset 0x00. It also shows in the count itself within one clock, because the count then either freezes or moves when it should not. A count that is off by even one is visible in the very next read of 0x08. For high-order errors, `ledOut` shows the fault on every cycle. Errors in the wrap path only appear once the count reaches all ones. For that reason a narrow second instance is run through its wrap point alongside the full-width one.

// File: rtl/cyclewatch_pkg.sv
package cyclewatch_pkg;
  // Strobes handed from the bus side to the counter datapath
  typedef struct packed {
    logic countEn;
    logic syncClr;
  } cwStrobe_t;

  localparam logic [1:0] RESP_OKAY = 2'b00;
  localparam int CTRL_BITS = 2;
endpackage

// File: rtl/cyclewatch_regs.sv
module cyclewatch_regs
  import cyclewatch_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 32,
  parameter int CTRL_OFF  = 'h00,
  parameter int COUNT_OFF = 'h08
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] awAddr,
  input  logic              awValid,
  output logic              awReady,
  input  logic [DATA_W-1:0] wData,
  input  logic [DATA_W/8-1:0] wStrb,
  input  logic              wValid,
  output logic              wReady,
  output logic [1:0]        bResp,
  output logic              bValid,
  input  logic              bReady,
  input  logic [ADDR_W-1:0] arAddr,
  input  logic              arValid,
  output logic              arReady,
  output logic [DATA_W-1:0] rData,
  output logic [1:0]        rResp,
  output logic              rValid,
  input  logic              rReady,
  input  logic [CNT_W-1:0]  cntIn,
  output cwStrobe_t         strb
);
  localparam int WORD_LSB = 2;
  localparam logic [ADDR_W-1:0] CTRL_ADDR  = ADDR_W'(CTRL_OFF);
  localparam logic [ADDR_W-1:0] COUNT_ADDR = ADDR_W'(COUNT_OFF);

  logic [CTRL_BITS-1:0] ctrlReg;
  logic wrFire, rdFire;
  logic wrHitCtrl, rdHitCtrl, rdHitCount;
  logic [DATA_W-1:0] rdMux;

  // Address and data are taken together, one transfer outstanding
  assign wrFire  = awValid && wValid && !bValid;
  assign awReady = wrFire;
  assign wReady  = wrFire;
  assign rdFire  = arValid && !rValid;
  assign arReady = !rValid;

  assign wrHitCtrl  = awAddr[ADDR_W-1:WORD_LSB] == CTRL_ADDR[ADDR_W-1:WORD_LSB];
  assign rdHitCtrl  = arAddr[ADDR_W-1:WORD_LSB] == CTRL_ADDR[ADDR_W-1:WORD_LSB];
  assign rdHitCount = arAddr[ADDR_W-1:WORD_LSB] == COUNT_ADDR[ADDR_W-1:WORD_LSB];

  always_comb begin
    rdMux = '0;
    if (rdHitCtrl)       rdMux = DATA_W'(ctrlReg);
    else if (rdHitCount) rdMux = DATA_W'(cntIn);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      bValid  <= 1'b0;
    end else begin
      if (wrFire && wrHitCtrl) ctrlReg <= wData[CTRL_BITS-1:0];
      if (wrFire)              bValid  <= 1'b1;
      else if (bReady)         bValid  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rValid <= 1'b0;
      rData  <= '0;
    end else if (rdFire) begin
      rValid <= 1'b1;
      rData  <= rdMux;
    end else if (rReady) begin
      rValid <= 1'b0;
    end
  end

  assign bResp = RESP_OKAY;
  assign rResp = RESP_OKAY;
  assign strb.countEn = ctrlReg[0];
  assign strb.syncClr = ctrlReg[1];

  logic unusedWr;
  assign unusedWr = ^{wData[DATA_W-1:CTRL_BITS], wStrb, awAddr[WORD_LSB-1:0], arAddr[WORD_LSB-1:0]};
endmodule

// File: rtl/cyclewatch_count.sv
module cyclewatch_count
  import cyclewatch_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int LED_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  cwStrobe_t        strb,
  output logic [CNT_W-1:0] cnt,
  output logic [LED_W-1:0] ledOut
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cnt <= '0;
    else if (strb.syncClr) cnt <= '0;
    else if (strb.countEn) cnt <= cnt + 1'b1;
  end

  generate
    if (LED_W <= CNT_W) begin : g_tap
      assign ledOut = cnt[CNT_W-1 -: LED_W];
    end else begin : g_pad
      assign ledOut = {cnt, {(LED_W-CNT_W){1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/cyclewatch_top.sv
module cyclewatch_top
  import cyclewatch_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int LED_W  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   awAddr,
  input  logic                awValid,
  output logic                awReady,
  input  logic [DATA_W-1:0]   wData,
  input  logic [DATA_W/8-1:0] wStrb,
  input  logic                wValid,
  output logic                wReady,
  output logic [1:0]          bResp,
  output logic                bValid,
  input  logic                bReady,
  input  logic [ADDR_W-1:0]   arAddr,
  input  logic                arValid,
  output logic                arReady,
  output logic [DATA_W-1:0]   rData,
  output logic [1:0]          rResp,
  output logic                rValid,
  input  logic                rReady,
  output logic [LED_W-1:0]    ledOut
);
  cwStrobe_t        strb;
  logic [CNT_W-1:0] cntVal;

  cyclewatch_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .CTRL_OFF('h00), .COUNT_OFF('h08)
  ) u_regs (
    .clk(clk), .rstN(rstN),
    .awAddr(awAddr), .awValid(awValid), .awReady(awReady),
    .wData(wData), .wStrb(wStrb), .wValid(wValid), .wReady(wReady),
    .bResp(bResp), .bValid(bValid), .bReady(bReady),
    .arAddr(arAddr), .arValid(arValid), .arReady(arReady),
    .rData(rData), .rResp(rResp), .rValid(rValid), .rReady(rReady),
    .cntIn(cntVal), .strb(strb)
  );

  cyclewatch_count #(.CNT_W(CNT_W), .LED_W(LED_W)) u_count (
    .clk(clk), .rstN(rstN), .strb(strb), .cnt(cntVal), .ledOut(ledOut)
  );
endmodule

// File: rtl/cyclewatch_chk.sv
module cyclewatch_chk
  import cyclewatch_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [CNT_W-1:0]  cnt,
  input cwStrobe_t         strb,
  input logic              bValid,
  input logic [1:0]        bResp,
  input logic              rValid,
  input logic              rReady,
  input logic [1:0]        rResp,
  input logic [DATA_W-1:0] rData
);
  p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (cnt == '0 && !bValid && !rValid));

  p_step_one_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.countEn && !strb.syncClr && cnt != '1) |=> cnt == $past(cnt) + 1'b1);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.countEn && !strb.syncClr) |=> $stable(cnt));

  p_clear_wins_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.syncClr |=> cnt == '0);

  p_rdata_steady_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rValid && !rReady) |=> (rValid && $stable(rData)));

  p_okay_resp_r7: assert property (@(posedge clk) disable iff (!rstN)
    (bValid || rValid) |-> (bResp == RESP_OKAY && rResp == RESP_OKAY));

  p_wrap_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.countEn && !strb.syncClr && cnt == '1) |=> cnt == '0);
endmodule

bind cyclewatch_top cyclewatch_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) chk (
  .clk(clk), .rstN(rstN), .cnt(cntVal), .strb(strb),
  .bValid(bValid), .bResp(bResp), .rValid(rValid), .rReady(rReady),
  .rResp(rResp), .rData(rData)
);

// File: tb/cyclewatch_top_test.sv
module cyclewatch_top_test;
  localparam int SMALL_W = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [11:0] awAddr = '0, arAddr = '0;
  logic awValid = 1'b0, wValid = 1'b0, arValid = 1'b0;
  logic bReady = 1'b1, rReady = 1'b1;
  logic [31:0] wData = '0;
  logic [3:0]  wStrb = 4'hF;
  logic awReady, wReady, bValid, arReady, rValid;
  logic [1:0] bResp, rResp;
  logic [31:0] rData;
  logic [7:0]  ledOut;
  logic awReadyS, wReadyS, bValidS, arReadyS, rValidS;
  logic [1:0] bRespS, rRespS;
  logic [31:0] rDataS;
  logic [7:0]  ledOutS;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  cyclewatch_top uut (
    .clk(clk), .rstN(rstN),
    .awAddr(awAddr), .awValid(awValid), .awReady(awReady),
    .wData(wData), .wStrb(wStrb), .wValid(wValid), .wReady(wReady),
    .bResp(bResp), .bValid(bValid), .bReady(bReady),
    .arAddr(arAddr), .arValid(arValid), .arReady(arReady),
    .rData(rData), .rResp(rResp), .rValid(rValid), .rReady(rReady),
    .ledOut(ledOut)
  );

  // Narrow copy on the same bus so wrap-around is reachable quickly
  cyclewatch_top #(.CNT_W(SMALL_W)) uutSmall (
    .clk(clk), .rstN(rstN),
    .awAddr(awAddr), .awValid(awValid), .awReady(awReadyS),
    .wData(wData), .wStrb(wStrb), .wValid(wValid), .wReady(wReadyS),
    .bResp(bRespS), .bValid(bValidS), .bReady(bReady),
    .arAddr(arAddr), .arValid(arValid), .arReady(arReadyS),
    .rData(rDataS), .rResp(rRespS), .rValid(rValidS), .rReady(rReady),
    .ledOut(ledOutS)
  );

  // Reference model built from the requirements
  logic [1:0]  refCtrl;
  logic [31:0] refCnt, expBig, expSmall;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refCtrl <= '0; refCnt <= '0; expBig <= '0; expSmall <= '0;
    end else begin
      if (refCtrl[1])      refCnt <= '0;
      else if (refCtrl[0]) refCnt <= refCnt + 1;
      if (awValid && wValid && awReady && awAddr == 12'h000) refCtrl <= wData[1:0];
      if (arValid && arReady) begin
        if (arAddr == 12'h000) begin
          expBig <= {30'd0, refCtrl}; expSmall <= {30'd0, refCtrl};
        end else if (arAddr == 12'h008) begin
          expBig <= refCnt; expSmall <= {22'd0, refCnt[SMALL_W-1:0]};
        end else begin
          expBig <= '0; expSmall <= '0;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R8: LED tap on every cycle out of reset, both widths
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(ledOut == refCnt[31:24], "R8 wide", {24'd0, ledOut}, {24'd0, refCnt[31:24]});
      check(ledOutS == refCnt[SMALL_W-1 -: 8], "R8 narrow", {24'd0, ledOutS}, {24'd0, refCnt[SMALL_W-1 -: 8]});
    end
  end

  logic [31:0] lastBig, lastSmall;

  task automatic axiWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    awAddr = a; wData = d; awValid = 1'b1; wValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    awValid = 1'b0; wValid = 1'b0;
    check(bValid && bValidS && bResp == 2'b00 && bRespS == 2'b00, "R7 write OKAY",
          {bValid, bValidS, bResp, bRespS}, 32'h30);
  endtask

  task automatic axiRead(input logic [11:0] a, input string req);
    @(negedge clk);
    arAddr = a; arValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    arValid = 1'b0;
    check(rValid && rResp == 2'b00, req, {rValid, rResp}, 32'h4);
    check(rData == expBig, req, rData, expBig);
    check(rDataS == expSmall, req, rDataS, expSmall);
    lastBig = rData; lastSmall = rDataS;
  endtask

  typedef struct packed {
    logic        isWr;
    logic [11:0] addr;
    logic [31:0] data;
    logic [7:0]  gap;
  } step_t;

  localparam int NSTEP = 22;
  localparam step_t STEPS [NSTEP] = '{
    '{1'b1, 12'h000, 32'h2,         8'd2},
    '{1'b1, 12'h000, 32'h1,         8'd10},
    '{1'b0, 12'h008, 32'h0,         8'd3},
    '{1'b0, 12'h000, 32'h0,         8'd0},
    '{1'b1, 12'h000, 32'h0,         8'd4},
    '{1'b0, 12'h008, 32'h0,         8'd5},
    '{1'b0, 12'h008, 32'h0,         8'd0},
    '{1'b1, 12'h008, 32'hDEAD_BEEF, 8'd3},
    '{1'b0, 12'h008, 32'h0,         8'd0},
    '{1'b0, 12'h000, 32'h0,         8'd0},
    '{1'b1, 12'h010, 32'h5,         8'd2},
    '{1'b0, 12'h000, 32'h0,         8'd0},
    '{1'b0, 12'h010, 32'h0,         8'd0},
    '{1'b0, 12'h004, 32'h0,         8'd0},
    '{1'b1, 12'h000, 32'h3,         8'd6},
    '{1'b0, 12'h008, 32'h0,         8'd0},
    '{1'b0, 12'h000, 32'h0,         8'd0},
    '{1'b1, 12'h000, 32'h1,         8'd20},
    '{1'b0, 12'h008, 32'h0,         8'd1},
    '{1'b1, 12'h000, 32'hFFFF_FFFC, 8'd3},
    '{1'b0, 12'h000, 32'h0,         8'd0},
    '{1'b0, 12'h008, 32'h0,         8'd0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] first;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state at the ports
    check(!bValid && !rValid && ledOut == 8'h00 && ledOutS == 8'h00, "R1 idle after reset",
          {bValid, rValid, ledOut, ledOutS}, 32'h0);
    axiRead(12'h000, "R1 ctrl after reset");
    check(lastBig == 32'h0, "R1 ctrl zero", lastBig, 32'h0);
    axiRead(12'h008, "R1 count after reset");
    check(lastBig == 32'h0, "R1 count zero", lastBig, 32'h0);

    // Table walk: reads checked against the model
    for (int i = 0; i < NSTEP; i++) begin
      if (STEPS[i].isWr) axiWrite(STEPS[i].addr, STEPS[i].data);
      else if (STEPS[i].addr == 12'h008) axiRead(STEPS[i].addr, "R6 table count read");
      else if (STEPS[i].addr == 12'h000) axiRead(STEPS[i].addr, "R5 table ctrl read");
      else axiRead(STEPS[i].addr, "R7 table unmapped read");
      for (int g = 0; g < STEPS[i].gap; g++) @(negedge clk);
    end

    // R2: reads accepted two cycles apart differ by two
    axiWrite(12'h000, 32'h2);
    axiWrite(12'h000, 32'h1);
    repeat (4) @(negedge clk);
    axiRead(12'h008, "R2 first");
    first = lastBig;
    axiRead(12'h008, "R2 second");
    check(lastBig - first == 32'd2, "R2 step of one", lastBig - first, 32'd2);

    // R3: stopped count does not move
    axiWrite(12'h000, 32'h0);
    axiRead(12'h008, "R3 first");
    first = lastBig;
    repeat (7) @(negedge clk);
    axiRead(12'h008, "R3 second");
    check(lastBig == first && first != 0, "R3 holds", lastBig, first);

    // R4: both bits set, clear wins
    axiWrite(12'h000, 32'h3);
    repeat (5) @(negedge clk);
    axiRead(12'h008, "R4 priority");
    check(lastBig == 32'h0, "R4 zero with both bits", lastBig, 32'h0);

    // R5: upper bits dropped
    axiWrite(12'h000, 32'hFFFF_FFF1);
    axiRead(12'h000, "R5 ctrl readback");
    check(lastBig == 32'h1, "R5 upper bits zero", lastBig, 32'h1);

    // R9: narrow instance wraps past 2^10
    axiWrite(12'h000, 32'h2);
    axiWrite(12'h000, 32'h1);
    repeat (1100) @(negedge clk);
    axiRead(12'h008, "R9 wrap read");
    check(lastBig >= 32'd1024 && lastBig < 32'd2048 && lastSmall == lastBig - 32'd1024,
          "R9 narrow wrapped", lastSmall, lastBig - 32'd1024);

    // R1 again: reset mid-run clears everything
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(ledOutS == 8'h00 && !rValid && !bValid, "R1 mid-run reset", {24'd0, ledOutS}, 32'h0);
    axiRead(12'h008, "R1 count after second reset");
    check(lastBig == 32'h0, "R1 count cleared", lastBig, 32'h0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule